// File: doc/BRIEF.md
# Windowed Packet Energy Detector

This block sits at the front of an OFDM receiver and decides when the air carries enough energy for the costlier packet synchronization stages to start. It takes one complex baseband sample per cycle, with 16-bit signed in-phase and quadrature parts and a valid flag. It keeps a running total of I²+Q² over the most recent 256 accepted samples.

The total is not tested on every sample. The first test happens once the window has filled after reset or after a clear. After that, the block tests once every 80 accepted samples, which is one OFDM symbol including its cyclic prefix. A test passes when the total is strictly above a programmable threshold. A pass produces a one-cycle detect pulse, together with the window energy and the index of the window's first sample. The block then latches a detected flag and emits no more pulses until software asserts the clear input. When a test fails, the block stays in search and tests the next hopped window.

Top module: `pwr_win_detect`

## Requirements
- R1: On a detection, `det_energy_o` equals the exact sum of I²+Q² over the 256 most recently accepted samples, the boundary sample included. I and Q are read as two's-complement values.
- R2: The first test of the threshold uses the 256th accepted sample after reset or clear. No detect pulse can occur before that sample.
- R3: After the first test, a new test occurs on every 80th accepted sample. The tested windows therefore start at sample indices 0, 80, 160 and so on, counted from 0 at the first accepted sample after reset or clear. On a detection, `det_start_o` carries that start index.
- R4: The threshold comparison is strictly greater-than. A window energy equal to `thresh_i` gives no detection. `thresh_i` is sampled on the clock edge that accepts the boundary sample.
- R5: `det_o` is high for exactly one cycle: the cycle after the clock edge that accepts a boundary sample whose test passes. At all other times `det_o` is low, and it is low after reset.
- R6: A detection sets `detected_o`, starting in the same cycle as the pulse. While `detected_o` is high, passing tests produce no pulse. `detected_o` stays high until a clear.
- R7: `clear_i` is synchronous and takes priority. On the edge where it is high, it drops `detected_o`, empties the window, and restarts the sample index and the hop count. Any sample presented in that same cycle is discarded.
- R8: A cycle with `smp_valid_i` low has no effect. The window does not move, the counts do not advance, and no pulse can follow it.
- R9: The sum cannot overflow. A window of 256 samples with I = Q = -32768 reports exactly 2^39.
- R10: `det_energy_o` and `det_start_o` are zero after reset. They change only on a detection and otherwise hold the values of the last detection, across clears included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_re_i | input | 16 | In-phase part, signed |
| smp_im_i | input | 16 | Quadrature part, signed |
| thresh_i | input | 40 | Energy threshold |
| clear_i | input | 1 | Synchronous restart and sticky release |
| det_o | output | 1 | One-cycle detect pulse |
| detected_o | output | 1 | Sticky detected flag |
| det_energy_o | output | 40 | Window energy of the last detection |
| det_start_o | output | 32 | Start index of the last detected window |

## Verification
The bound checker watches several properties on every cycle. It checks that each pulse lasts one cycle and is covered by the sticky flag. It checks that a reported energy lies above the threshold sampled one cycle earlier, and that a reported start index is a multiple of the hop. It also checks that a clear drops the flag, that a pulse follows only a valid, uncleared sample, and that the reported values hold between detections. Some behaviours only the bench scenarios can show, because the bench compares against its own sum of squares. These are the exact window energy, the placement of the first test at the 256th sample, the hop spacing across invalid cycles, the strict comparison at equality, and the full-scale sum.

// File: rtl/pwr_win_pkg.sv
package pwr_win_pkg;
  localparam int unsigned SMP_W_DEF = 16;
  localparam int unsigned WIN_DEF   = 256;
  localparam int unsigned HOP_DEF   = 80;
  localparam int unsigned IDX_W_DEF = 32;

  // width of a sum of n squared magnitudes of w-bit signed parts
  function automatic int unsigned acc_width(input int unsigned w, input int unsigned n);
    return 2 * w + $clog2(n);
  endfunction
endpackage

// File: rtl/pwr_sq_mag.sv
module pwr_sq_mag #(
  parameter int unsigned SMP_W = 16,
  localparam int unsigned E_W  = 2 * SMP_W
) (
  input  logic signed [SMP_W-1:0] re_i,
  input  logic signed [SMP_W-1:0] im_i,
  output logic        [E_W-1:0]   mag_o
);
  logic signed [E_W-1:0] p_re, p_im;

  always_comb begin
    p_re  = re_i * re_i;
    p_im  = im_i * im_i;
    mag_o = $unsigned(p_re) + $unsigned(p_im);
  end
endmodule

// File: rtl/pwr_win_sum.sv
module pwr_win_sum #(
  parameter int unsigned E_W     = 32,
  parameter int unsigned ACC_W   = 40,
  parameter int unsigned WIN_LEN = 256,
  localparam int unsigned PTR_W  = $clog2(WIN_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic             full_i,
  input  logic [E_W-1:0]   mag_i,
  output logic [ACC_W-1:0] sum_nxt_o
);
  logic [E_W-1:0]   dly_q [WIN_LEN];
  logic [PTR_W-1:0] wp_q, wp_nxt;
  logic [ACC_W-1:0] sum_q;
  logic [E_W-1:0]   leaving;

  generate
    if (WIN_LEN == (1 << PTR_W)) begin : g_pow2
      assign wp_nxt = wp_q + 1'b1;
    end else begin : g_wrap
      assign wp_nxt = (wp_q == PTR_W'(WIN_LEN - 1)) ? '0 : wp_q + 1'b1;
    end
  endgenerate

  assign leaving   = full_i ? dly_q[wp_q] : '0;
  assign sum_nxt_o = sum_q + ACC_W'(mag_i) - ACC_W'(leaving);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      sum_q <= '0;
    end else if (clear_i) begin
      wp_q  <= '0;
      sum_q <= '0;
    end else if (push_i) begin
      wp_q  <= wp_nxt;
      sum_q <= sum_nxt_o;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !clear_i) dly_q[wp_q] <= mag_i;
  end
endmodule

// File: rtl/pwr_hop_ctrl.sv
module pwr_hop_ctrl #(
  parameter int unsigned WIN_LEN = 256,
  parameter int unsigned HOP_LEN = 80,
  parameter int unsigned IDX_W   = 32,
  localparam int unsigned FILL_W = $clog2(WIN_LEN),
  localparam int unsigned HOP_W  = $clog2(HOP_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  output logic             full_o,
  output logic             eval_o,
  output logic [IDX_W-1:0] start_o
);
  logic [FILL_W-1:0] fill_q;
  logic [HOP_W-1:0]  hop_q;
  logic              fill_end, hop_end;

  assign fill_end = (fill_q == FILL_W'(WIN_LEN - 1));
  assign hop_end  = (hop_q == HOP_W'(HOP_LEN - 1));
  assign eval_o   = push_i && (full_o ? hop_end : fill_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q  <= '0;
      hop_q   <= '0;
      full_o  <= 1'b0;
      start_o <= '0;
    end else if (clear_i) begin
      fill_q  <= '0;
      hop_q   <= '0;
      full_o  <= 1'b0;
      start_o <= '0;
    end else if (push_i) begin
      if (!full_o) begin
        fill_q <= fill_q + 1'b1;
        if (fill_end) full_o <= 1'b1;
        hop_q  <= '0;
      end else begin
        hop_q <= hop_end ? '0 : hop_q + 1'b1;
      end
      if (eval_o) start_o <= start_o + IDX_W'(HOP_LEN);
    end
  end
endmodule

// File: rtl/pwr_win_detect.sv
module pwr_win_detect
  import pwr_win_pkg::*;
#(
  parameter int unsigned SMP_W   = SMP_W_DEF,
  parameter int unsigned WIN_LEN = WIN_DEF,
  parameter int unsigned HOP_LEN = HOP_DEF,
  parameter int unsigned IDX_W   = IDX_W_DEF,
  localparam int unsigned E_W    = 2 * SMP_W,
  localparam int unsigned ACC_W  = acc_width(SMP_W, WIN_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_re_i,
  input  logic [SMP_W-1:0] smp_im_i,
  input  logic [ACC_W-1:0] thresh_i,
  input  logic             clear_i,
  output logic             det_o,
  output logic             detected_o,
  output logic [ACC_W-1:0] det_energy_o,
  output logic [IDX_W-1:0] det_start_o
);
  logic             push, full, eval, hit;
  logic [E_W-1:0]   mag;
  logic [ACC_W-1:0] sum_nxt;
  logic [IDX_W-1:0] win_start;

  assign push = smp_valid_i && !clear_i;

  pwr_sq_mag #(.SMP_W(SMP_W)) u_mag (
    .re_i  ($signed(smp_re_i)),
    .im_i  ($signed(smp_im_i)),
    .mag_o (mag)
  );

  pwr_hop_ctrl #(.WIN_LEN(WIN_LEN), .HOP_LEN(HOP_LEN), .IDX_W(IDX_W)) u_hop (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .push_i  (push),
    .full_o  (full),
    .eval_o  (eval),
    .start_o (win_start)
  );

  pwr_win_sum #(.E_W(E_W), .ACC_W(ACC_W), .WIN_LEN(WIN_LEN)) u_sum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .push_i    (push),
    .full_i    (full),
    .mag_i     (mag),
    .sum_nxt_o (sum_nxt)
  );

  assign hit = eval && (sum_nxt > thresh_i) && !detected_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_o        <= 1'b0;
      detected_o   <= 1'b0;
      det_energy_o <= '0;
      det_start_o  <= '0;
    end else if (clear_i) begin
      det_o      <= 1'b0;
      detected_o <= 1'b0;
    end else begin
      det_o <= hit;
      if (hit) begin
        detected_o   <= 1'b1;
        det_energy_o <= sum_nxt;
        det_start_o  <= win_start;
      end
    end
  end
endmodule

// File: rtl/pwr_win_detect_chk.sv
module pwr_win_detect_chk #(
  parameter int unsigned ACC_W   = 40,
  parameter int unsigned IDX_W   = 32,
  parameter int unsigned HOP_LEN = 80
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_valid_i,
  input logic             clear_i,
  input logic [ACC_W-1:0] thresh_i,
  input logic             det_o,
  input logic             detected_o,
  input logic [ACC_W-1:0] det_energy_o,
  input logic [IDX_W-1:0] det_start_o
);
  p_single_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o |=> !det_o);

  p_pulse_sets_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o |-> detected_o);

  p_strict_above_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o |-> (det_energy_o > $past(thresh_i)));

  p_start_on_hop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o |-> ((det_start_o % IDX_W'(HOP_LEN)) == '0));

  p_clear_drops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!detected_o && !det_o));

  p_needs_sample_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o |-> ($past(smp_valid_i) && !$past(clear_i)));

  p_hold_report_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !det_o |-> ($stable(det_energy_o) && $stable(det_start_o)));
endmodule

bind pwr_win_detect pwr_win_detect_chk #(
  .ACC_W(ACC_W), .IDX_W(IDX_W), .HOP_LEN(HOP_LEN)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .smp_valid_i  (smp_valid_i),
  .clear_i      (clear_i),
  .thresh_i     (thresh_i),
  .det_o        (det_o),
  .detected_o   (detected_o),
  .det_energy_o (det_energy_o),
  .det_start_o  (det_start_o)
);

// File: tb/tb_pwr_win_detect.sv
`timescale 1ns/1ps
module tb_pwr_win_detect;
  localparam int WIN = 256;
  localparam int HOP = 80;
  localparam int LIMIT = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic [15:0] smp_re_i = '0;
  logic [15:0] smp_im_i = '0;
  logic [39:0] thresh_i = '0;
  logic        clear_i = 1'b0;
  logic        det_o, detected_o;
  logic [39:0] det_energy_o;
  logic [31:0] det_start_o;

  pwr_win_detect dut (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, failures = 0, cyc = 0;
  longint ring [WIN];
  longint n = 0, last_e = 0, last_s = 0;
  bit     sticky = 0, exp_det = 0;
  int unsigned lfsr = 32'h1ACE_B00C;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == LIMIT) begin
      failures++;
      $display("FAIL watchdog: act=%0d cycles exp<%0d", cyc, LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: act=%0d exp=%0d (n=%0d)", tag, act, exp, n);
    end
  endtask

  // entered at a negedge; applies inputs, advances one clock, checks at next negedge
  task automatic step(input bit v, input logic signed [15:0] re, input logic signed [15:0] im,
                      input bit clr, input string tag);
    longint sum;
    smp_valid_i = v; smp_re_i = re; smp_im_i = im; clear_i = clr;
    @(negedge clk_i);
    exp_det = 0;
    if (clr) begin
      n = 0; sticky = 0;
    end else if (v) begin
      ring[n % WIN] = longint'(re) * longint'(re) + longint'(im) * longint'(im);
      n++;
      if (n >= WIN && ((n - WIN) % HOP) == 0) begin
        sum = 0;
        for (int k = 0; k < WIN; k++) sum += ring[k];
        if (sum > longint'(thresh_i) && !sticky) begin
          exp_det = 1; sticky = 1; last_e = sum; last_s = n - WIN;
        end
      end
    end
    chk(det_o == exp_det, tag, det_o, exp_det);
    chk(detected_o == sticky, "R6", detected_o, sticky);
    chk(longint'(det_energy_o) == last_e, "R1", longint'(det_energy_o), last_e);
    chk(longint'(det_start_o) == last_s, "R3", longint'(det_start_o), last_s);
    smp_valid_i = 0; clear_i = 0;
  endtask

  function automatic logic [15:0] rnd();
    lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
    return lfsr[15:0];
  endfunction

  initial begin
    for (int k = 0; k < WIN; k++) ring[k] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset state (R5, R10)
    chk(det_o == 0, "R5", det_o, 0);
    chk(detected_o == 0, "R6", detected_o, 0);
    chk(det_energy_o == 0, "R10", longint'(det_energy_o), 0);

    // R2: nothing before the 256th sample, pulse on it
    thresh_i = '0;
    for (int k = 0; k < WIN - 1; k++) step(1, 16'sd1000, -16'sd2000, 0, "R2");
    step(1, 16'sd1000, -16'sd2000, 0, "R2");
    chk(det_o == 1, "R2", det_o, 1);
    // R6: passing tests suppressed while flagged
    for (int k = 0; k < 2 * HOP; k++) step(1, 16'sd1000, -16'sd2000, 0, "R6");

    // R7 clear, R8 invalid cycles with garbage, R4 equality
    step(1, 16'sd77, 16'sd77, 1, "R7");
    thresh_i = 40'd6400;
    for (int k = 0; k < WIN - 1; k++) begin
      if (k % 3 == 0) step(0, 16'sh7fff, 16'sh7fff, 0, "R8");
      step(1, 16'sd3, 16'sd4, 0, "R8");
    end
    step(1, 16'sd3, 16'sd4, 0, "R4");
    chk(det_o == 0, "R4", det_o, 0);
    thresh_i = 40'd6399;
    for (int k = 0; k < HOP - 1; k++) begin
      step(0, 16'sd9, 16'sd9, 0, "R8");
      step(1, 16'sd3, 16'sd4, 0, "R3");
    end
    step(1, 16'sd3, 16'sd4, 0, "R3");
    chk(det_o == 1 && det_start_o == HOP, "R3", longint'(det_start_o), HOP);
    for (int k = 0; k < 5; k++) step(0, 16'sd0, 16'sd0, 0, "R10");

    // R9: full-scale window
    step(0, 16'sd0, 16'sd0, 1, "R7");
    thresh_i = 40'h7F_FFFF_FFFF;
    for (int k = 0; k < WIN; k++) step(1, -16'sd32768, -16'sd32768, 0, "R9");
    chk(det_energy_o == 40'h80_0000_0000, "R9", longint'(det_energy_o), 64'h80_0000_0000);

    // R7: partial fill discarded by clear
    step(0, 16'sd0, 16'sd0, 1, "R7");
    for (int k = 0; k < 100; k++) step(1, 16'sd30000, 16'sd30000, 0, "R7");
    step(1, 16'sd30000, 16'sd30000, 1, "R7");
    thresh_i = '0;
    for (int k = 0; k < WIN; k++) step(1, 16'sd1, 16'sd0, 0, "R7");
    chk(det_energy_o == 40'd256 && det_start_o == 0, "R7", longint'(det_energy_o), 256);

    // sweep: loud/quiet bursts, sparse invalids, clear after each detection
    step(0, 16'sd0, 16'sd0, 1, "R7");
    thresh_i = 40'h10_0000_0000;
    for (int k = 0; k < 4000; k++) begin
      logic [15:0] a, b;
      bit loud, v;
      a = rnd(); b = rnd();
      loud = ((k / 170) % 2) == 1;
      v = (lfsr[20:19] != 2'b00);
      if (!loud) begin a = 16'($signed(a) >>> 9); b = 16'($signed(b) >>> 9); end
      step(v, a, b, 0, "R3");
      if (exp_det) step(0, 16'sd0, 16'sd0, 1, "R7");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule